// File: doc/BRIEF.md
# Parallel Character-Display Bus Driver

This block is the host side of the parallel bus on a character display controller. The bus has a register select line, a read/write line, an enable strobe and an eight-bit data bus. The block performs one register access per request. A request carries a select bit, a direction bit, a write byte and a bus-width mode. The engine drives select and direction, pulses enable, and either drives the data lines or samples them. Every timing minimum of the bus is turned into a count of system clock cycles by rounding up.

In narrow mode only the upper four data lines carry information. Each byte is moved as two transfers, upper half first, and each transfer gets its own enable pulse. Reads return the sampled byte together with a one-cycle completion pulse. Order of commands, waiting between commands and display contents belong to the caller.

Top module: `char_bus_driver`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the completion cycle.
- R2: Enable rises exactly AS cycles after the accepting clock edge, where AS = ceil(40 ns / clock period) with a minimum of 1. Select and direction carry the request's values from the first cycle after acceptance until completion.
- R3: Each enable pulse lasts exactly HIGH cycles. HIGH is the largest of ceil(230 ns), ceil(80 ns) and ceil(160 ns)+1, each in clock periods with a minimum of 1.
- R4: For at least HOLD = ceil(10 ns) cycles after enable falls, select, direction and the driven data keep the values they had while enable was high.
- R5: Let PAD = max(0, ceil(500 ns) − AS − HIGH − HOLD). After a falling enable, the next rising enable or the completion comes exactly HOLD+PAD cycles later, plus AS cycles if it is a rising enable. Rise-to-rise spacing is therefore at least ceil(500 ns) cycles.
- R6: A wide-mode write (mode bit 0) gives one enable pulse. During it the data lines carry the whole byte and the output-enable is high throughout the access.
- R7: A narrow-mode write (mode bit 1) gives two enable pulses. During the first, data bits 7..4 carry the byte's bits 7..4. During the second, they carry bits 3..0. Data bits 3..0 are driven as 0.
- R8: During a read the output-enable is low for the whole access. The data lines are sampled in the last cycle that enable is high. A wide read returns the sampled byte. A narrow read returns {first sample bits 7..4, second sample bits 7..4}.
- R9: `rdata` shows the read result in the completion cycle and keeps it until the next read completes. A write leaves `rdata` unchanged.
- R10: `done` is a pulse one cycle long. It comes in the same cycle that `req_ready` returns high.
- R11: After reset, enable is low, `req_ready` is high, `done` is low, output-enable is low, and select and direction are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_rs | input | 1 | Register select value for the access |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_nibble | input | 1 | 1 = four-bit transfers on data bits 7..4 |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| bus_rs | output | 1 | Register select line |
| bus_rw | output | 1 | Read/write line |
| bus_e | output | 1 | Enable strobe |
| bus_db_out | output | 8 | Data driven onto the bus |
| bus_db_oe | output | 1 | Output-enable for the data lines |
| bus_db_in | input | 8 | Data sampled from the bus |

## Verification
The bench builds the block with a 20 ns clock period. This gives AS=2, HIGH=12, HOLD=1 and PAD=10. The enable width is therefore set by the pulse-width minimum rather than by the read delay, and a nonzero padding phase sits between enable pulses. All 256 byte values are swept through wide writes, narrow writes, wide reads and narrow reads. Read data is shown on the bus only once the 160 ns delay has passed, and garbage is shown before that and after the hold. A sample taken one cycle early or late therefore returns the wrong byte.

// File: rtl/charbus_pkg.sv
package charbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_HIGH,
    PH_HOLD,
    PH_PAD
  } phase_t;

  // ceil(ns / period) with a floor of one cycle
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles left to fill after the busy part of a strobe cycle
  function automatic int unsigned pad_cycles(input int unsigned cyc,
                                             input int unsigned busy);
    return (cyc > busy) ? (cyc - busy) : 0;
  endfunction

endpackage

// File: rtl/charbus_phase_timer.sv
module charbus_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/charbus_lane_mux.sv
module charbus_lane_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_in,
  input  logic              nibble_mode,
  input  logic              second_half,
  output logic [DATA_W-1:0] lanes
);
  localparam int unsigned HALF_W = DATA_W / 2;

  always_comb begin
    if (!nibble_mode)
      lanes = byte_in;
    else if (!second_half)
      lanes = {byte_in[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
    else
      lanes = {byte_in[HALF_W-1:0], {HALF_W{1'b0}}};
  end
endmodule

// File: rtl/char_bus_driver.sv
module char_bus_driver
  import charbus_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 20000,
  parameter int unsigned ADDR_SU_NS    = 40,
  parameter int unsigned ADDR_HD_NS    = 10,
  parameter int unsigned E_WIDTH_NS    = 230,
  parameter int unsigned E_CYCLE_NS    = 500,
  parameter int unsigned WDATA_SU_NS   = 80,
  parameter int unsigned WDATA_HD_NS   = 10,
  parameter int unsigned RDATA_DLY_NS  = 160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_rs,
  input  logic              req_rw,
  input  logic              req_nibble,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_rs,
  output logic              bus_rw,
  output logic              bus_e,
  output logic [DATA_W-1:0] bus_db_out,
  output logic              bus_db_oe,
  input  logic [DATA_W-1:0] bus_db_in
);
  localparam int unsigned HALF_W   = DATA_W / 2;
  localparam int unsigned AS_CYC   = ns_to_cycles(ADDR_SU_NS, CLK_PERIOD_PS);
  localparam int unsigned HIGH_CYC = umax(umax(ns_to_cycles(E_WIDTH_NS, CLK_PERIOD_PS),
                                               ns_to_cycles(WDATA_SU_NS, CLK_PERIOD_PS)),
                                          ns_to_cycles(RDATA_DLY_NS, CLK_PERIOD_PS) + 1);
  localparam int unsigned HOLD_CYC = umax(ns_to_cycles(ADDR_HD_NS, CLK_PERIOD_PS),
                                          ns_to_cycles(WDATA_HD_NS, CLK_PERIOD_PS));
  localparam int unsigned PAD_CYC  = pad_cycles(ns_to_cycles(E_CYCLE_NS, CLK_PERIOD_PS),
                                                AS_CYC + HIGH_CYC + HOLD_CYC);
  localparam int unsigned MAX_CYC  = umax(umax(AS_CYC, HIGH_CYC), umax(HOLD_CYC, PAD_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  phase_t            phase, phase_nxt;
  logic              rs_q, rw_q, nib_q, second_q;
  logic [DATA_W-1:0] wbyte_q, rbuf_q;
  logic              tmr_load, tmr_last, finish;
  logic [CNT_W-1:0]  tmr_val;

  // named internal events, observed by the bound checker
  logic ev_accept, ev_fall, ev_finish;
  assign ev_accept = (phase == PH_IDLE) && req_valid;
  assign ev_fall   = (phase == PH_HIGH) && tmr_last;
  assign ev_finish = finish;

  always_comb begin
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    finish    = 1'b0;
    case (phase)
      PH_IDLE:  if (req_valid) begin
                  phase_nxt = PH_SETUP; tmr_load = 1'b1; tmr_val = CNT_W'(AS_CYC);
                end
      PH_SETUP: if (tmr_last) begin
                  phase_nxt = PH_HIGH; tmr_load = 1'b1; tmr_val = CNT_W'(HIGH_CYC);
                end
      PH_HIGH:  if (tmr_last) begin
                  phase_nxt = PH_HOLD; tmr_load = 1'b1; tmr_val = CNT_W'(HOLD_CYC);
                end
      PH_HOLD:  if (tmr_last) begin
                  if (PAD_CYC != 0) begin
                    phase_nxt = PH_PAD; tmr_load = 1'b1; tmr_val = CNT_W'(PAD_CYC);
                  end else begin
                    finish = 1'b1;
                  end
                end
      PH_PAD:   if (tmr_last) finish = 1'b1;
      default:  phase_nxt = PH_IDLE;
    endcase
    if (finish) begin
      if (nib_q && !second_q) begin
        phase_nxt = PH_SETUP; tmr_load = 1'b1; tmr_val = CNT_W'(AS_CYC);
      end else begin
        phase_nxt = PH_IDLE;
      end
    end
  end

  charbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      rs_q     <= 1'b0;
      rw_q     <= 1'b0;
      nib_q    <= 1'b0;
      second_q <= 1'b0;
      wbyte_q  <= '0;
      rbuf_q   <= '0;
      rdata    <= '0;
      done     <= 1'b0;
    end else begin
      phase <= phase_nxt;
      done  <= 1'b0;
      if (ev_accept) begin
        rs_q     <= req_rs;
        rw_q     <= req_rw;
        nib_q    <= req_nibble;
        second_q <= 1'b0;
        wbyte_q  <= req_wdata;
      end
      if (ev_fall && rw_q) begin
        if (!nib_q)         rbuf_q <= bus_db_in;
        else if (!second_q) rbuf_q[DATA_W-1:HALF_W] <= bus_db_in[DATA_W-1:HALF_W];
        else                rbuf_q[HALF_W-1:0]      <= bus_db_in[DATA_W-1:HALF_W];
      end
      if (finish) begin
        if (nib_q && !second_q) begin
          second_q <= 1'b1;
        end else begin
          done <= 1'b1;
          if (rw_q) rdata <= rbuf_q;
        end
      end
    end
  end

  charbus_lane_mux #(.DATA_W(DATA_W)) u_lanes (
    .byte_in     (wbyte_q),
    .nibble_mode (nib_q),
    .second_half (second_q),
    .lanes       (bus_db_out)
  );

  assign req_ready = (phase == PH_IDLE);
  assign bus_e     = (phase == PH_HIGH);
  assign bus_rs    = rs_q;
  assign bus_rw    = rw_q;
  assign bus_db_oe = (phase != PH_IDLE) && !rw_q;
endmodule

// File: rtl/charbus_chk.sv
module charbus_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HIGH_CYC = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              bus_rs,
  input logic              bus_rw,
  input logic              bus_e,
  input logic              bus_db_oe,
  input logic [DATA_W-1:0] bus_db_out,
  input logic              ev_accept
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (bus_e) hi_cnt <= hi_cnt + 16'd1;
    else            hi_cnt <= '0;
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> !req_ready);

  // R2
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(bus_rs) && $stable(bus_rw)));

  // R3
  e_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_e) |-> (hi_cnt == 16'(HIGH_CYC)));

  // R4
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_e) |-> ($stable(bus_db_out) && $stable(bus_rs) && $stable(bus_rw)));

  // R6
  wdata_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_e && $past(bus_e)) |-> $stable(bus_db_out));

  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rw |-> !bus_db_oe);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_e));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind char_bus_driver charbus_chk #(.DATA_W(DATA_W), .HIGH_CYC(HIGH_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .bus_rs     (bus_rs),
  .bus_rw     (bus_rw),
  .bus_e      (bus_e),
  .bus_db_oe  (bus_db_oe),
  .bus_db_out (bus_db_out),
  .ev_accept  (ev_accept)
);

// File: tb/test_char_bus_driver.sv
`timescale 1ns/1ps
module test_char_bus_driver;
  localparam int CLK_NS = 20;
  localparam int CLK_PS = CLK_NS * 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_rs = 1'b0, req_rw = 1'b0, req_nibble = 1'b0;
  logic [7:0] req_wdata = 8'h00, bus_db_in = 8'h00;
  logic       req_ready, done, bus_rs, bus_rw, bus_e, bus_db_oe;
  logic [7:0] rdata, bus_db_out;

  int n_checks = 0, n_errors = 0;
  logic [7:0] last_read = 8'h00;

  always #(CLK_NS/2) clk = ~clk;

  char_bus_driver #(.CLK_PERIOD_PS(CLK_PS)) i_char_bus_driver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rs(req_rs), .req_rw(req_rw), .req_nibble(req_nibble), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_e(bus_e),
    .bus_db_out(bus_db_out), .bus_db_oe(bus_db_oe), .bus_db_in(bus_db_in)
  );

  // timing minimums restated with real arithmetic
  function automatic int cyc(input int ns);
    int c;
    c = int'($ceil(real'(ns) * 1000.0 / real'(CLK_PS)));
    return (c < 1) ? 1 : c;
  endfunction

  int AS, HIGH, HOLD, PAD, CYC, DLY;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_exp(input logic nib, input logic [7:0] v, input int k);
    if (!nib) return v;
    return (k == 0) ? {v[7:4], 4'h0} : {v[3:0], 4'h0};
  endfunction

  task automatic access(input logic rs, input logic rw, input logic nib,
                        input logic [7:0] wv, input logic [7:0] rv);
    int npulse = nib ? 2 : 1;
    int rises[2];
    int falls[2];
    int nr = 0, nf = 0, t = 0, done_t = -1;
    logic prev_e = 1'b0;
    bit bad_ctrl = 0, bad_data = 0, bad_hold = 0, bad_oe = 0;
    logic [7:0] fall_db = 8'h00;
    logic [7:0] in_val;
    @(negedge clk);
    req_rs = rs; req_rw = rw; req_nibble = nib; req_wdata = wv; req_valid = 1'b1;
    check(req_ready == 1'b1, "R1", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~wv;
    check(req_ready == 1'b0, "R1", req_ready, 0);
    while (t < 400) begin
      if (bus_e && !prev_e && nr < 2) begin rises[nr] = t; nr++; end
      if (!bus_e && prev_e && nf < 2) begin falls[nf] = t; nf++; fall_db = bus_db_out; end
      if (bus_rs !== rs || bus_rw !== rw) bad_ctrl = 1;
      if (done) begin done_t = t; break; end
      if (bus_db_oe !== !rw) bad_oe = 1;
      if (bus_e && !rw && nr > 0 && bus_db_out !== lane_exp(nib, wv, nr - 1)) bad_data = 1;
      if (!bus_e && !rw && nf > 0 && (t - falls[nf-1]) < HOLD && bus_db_out !== fall_db) bad_hold = 1;
      in_val = nib ? ((nr == 2) ? {rv[3:0], 4'hC} : {rv[7:4], 4'h3}) : rv;
      if (bus_e && nr > 0 && (t - rises[nr-1] + 1) >= DLY) bus_db_in = in_val;
      else bus_db_in = ~in_val;
      prev_e = bus_e;
      t++;
      @(negedge clk);
    end
    check(done_t >= 0, "R10", done_t, 0);
    check(req_ready == 1'b1, "R10", req_ready, 1);
    check(!bad_ctrl, "R2", bad_ctrl, 0);
    check(!bad_hold, "R4", bad_hold, 0);
    check(nr == npulse && nf == npulse, nib ? "R7" : "R6", nr, npulse);
    if (nr == npulse && nf == npulse) begin
      check(rises[0] == AS, "R2", rises[0], AS);
      for (int k = 0; k < npulse; k++)
        check(falls[k] - rises[k] == HIGH, "R3", falls[k] - rises[k], HIGH);
      check(done_t - falls[npulse-1] == HOLD + PAD, "R5", done_t - falls[npulse-1], HOLD + PAD);
      if (npulse == 2) begin
        check(rises[1] - rises[0] == HIGH + HOLD + PAD + AS, "R5", rises[1] - rises[0],
              HIGH + HOLD + PAD + AS);
        check(rises[1] - rises[0] >= CYC, "R5", rises[1] - rises[0], CYC);
      end
    end
    if (rw) begin
      check(!bad_oe, "R8", bad_oe, 0);
      check(rdata == rv, "R8", rdata, rv);
      last_read = rv;
    end else begin
      check(!bad_oe, nib ? "R7" : "R6", bad_oe, 0);
      check(!bad_data, nib ? "R7" : "R6", bad_data, 0);
      check(rdata == last_read, "R9", rdata, last_read);
    end
    @(negedge clk);
    check(done == 1'b0, "R10", done, 0);
    check(rdata == last_read, "R9", rdata, last_read);
  endtask

  initial begin
    AS   = cyc(40);
    DLY  = cyc(160);
    HIGH = cyc(230);
    if (cyc(80) > HIGH) HIGH = cyc(80);
    if (DLY + 1 > HIGH) HIGH = DLY + 1;
    HOLD = cyc(10);
    CYC  = cyc(500);
    PAD  = CYC - AS - HIGH - HOLD;
    if (PAD < 0) PAD = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(bus_e == 0 && req_ready == 1 && done == 0, "R11", {bus_e, req_ready, done}, 3'b010);
    check(bus_db_oe == 0 && bus_rs == 0 && bus_rw == 0, "R11", {bus_db_oe, bus_rs, bus_rw}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1 && bus_e == 0, "R11", {req_ready, bus_e}, 2'b10);
    for (int v = 0; v < 256; v++) begin
      access(v[0], 1'b0, 1'b0, 8'(v), 8'h00);
      access(v[1], 1'b0, 1'b1, 8'(v), 8'h00);
      access(v[2], 1'b1, 1'b0, 8'h00, 8'(v));
      access(v[3], 1'b1, 1'b1, 8'h00, 8'(255 - v));
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule